// File: doc/BRIEF.md
# Boot ROM Overlay Memory Decoder

This block sits on the 16-bit address bus of a small 8-bit processor. It turns each bus request into an effective address and steers it to an external single-port RAM, a 64-byte boot ROM held inside the block, or a 16-byte register window. The block forms the effective address in one of four ways: an absolute address, a direct-page address built from a page flag and an 8-bit offset, a stack push, or a stack pop. The stack pointer is kept inside the block.

The boot ROM covers the top 64 bytes of the address space for reads only. While the overlay flag is set, reads there return ROM bytes. Writes to that range always fall through to the RAM underneath. This lets boot code copy itself into RAM before it hides the ROM. A second flag gates every write into RAM, and that includes writes aimed at the register window. Both flags are loaded through a small flag port.

Read data comes out one cycle after the request. This matches the one-cycle latency of the synchronous RAM. A registered source select chooses between RAM data, ROM data and window data.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset, the overlay flag and the RAM-writable flag are both 1, sp_o equals SP_RESET (default 0xEF), rvalid_o is 0 and ram_we_o is 0.
- R2: While the overlay flag is 1, a read of address 0xFFC0..0xFFFF returns ROM byte addr[5:0] on rdata_o in the cycle after the request. The default ROM byte i is ((i*29) mod 256) xor 0x5A.
- R3: While the overlay flag is 0, a read of 0xFFC0..0xFFFF returns the RAM byte at that address.
- R4: A write to any address, including 0xFFC0..0xFFFF while the overlay is enabled, asserts ram_we_o and ram_en_o with ram_addr_o equal to the effective address and ram_wdata_o equal to wdata_i, whenever the RAM-writable flag is 1.
- R5: While the RAM-writable flag is 0, writes never assert ram_we_o, and the RAM contents stay unchanged.
- R6: An access whose address satisfies (addr & 0xFFF0) == 0x00F0 asserts win_sel_o in the same cycle. A read there returns win_rdata_i in the following cycle. A write there also reaches RAM, subject to R4 and R5.
- R7: kind_i = 1 (direct page) forms the address {7'b0, page_i, addr_i[7:0]}. kind_i = 0 (absolute) uses addr_i unchanged. Both obey we_i.
- R8: kind_i = 2 (push) is always a write: it writes to 0x0100 | sp_o and sp_o decrements by one after the request.
- R9: kind_i = 3 (pop) is always a read: sp_o increments by one and the read uses 0x0100 | (sp_o + 1).
- R10: Any read that falls outside the ROM window (or inside it with the overlay off) and outside the register window returns RAM data. For every read, rvalid_o is high exactly one cycle after the request.
- R11: A pulse on flag_we_i loads flag_rom_en_i into the overlay flag and flag_ram_wr_i into the RAM-writable flag. The new values take effect from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request valid |
| kind_i | input | 2 | 0 absolute, 1 direct page, 2 push, 3 pop |
| we_i | input | 1 | Write for absolute or direct-page kinds |
| page_i | input | 1 | Direct-page select flag |
| addr_i | input | 16 | Absolute address or offset in bits [7:0] |
| wdata_i | input | 8 | Write data |
| flag_we_i | input | 1 | Load the two flags |
| flag_rom_en_i | input | 1 | New overlay flag value |
| flag_ram_wr_i | input | 1 | New RAM-writable flag value |
| win_rdata_i | input | 8 | Register window read data, one cycle after win_sel_o |
| ram_rdata_i | input | 8 | RAM read data, one cycle after ram_en_o |
| ram_en_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 16 | Effective address |
| ram_wdata_o | output | 8 | RAM write data |
| win_sel_o | output | 1 | Access falls in the register window |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Read data |
| sp_o | output | 8 | Stack pointer |

## Verification
The assertions check these rules on every cycle: that a write strobe never appears while the writable flag is clear, the stack pointer step on each push and pop, the push address, the one-cycle read valid, and that overlay reads and window reads return the ROM byte and the window data respectively. The bench scenarios show the behaviour that depends on history. A write under the ROM must become visible only after the overlay is turned off. A write blocked by the cleared flag must leave the old RAM byte in place. A page-1 direct-page write must be readable at the matching absolute address, and stack bytes must come back in last-in, first-out order.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    ACC_ABS  = 2'd0,
    ACC_DP   = 2'd1,
    ACC_PUSH = 2'd2,
    ACC_POP  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SRC_RAM = 2'd0,
    SRC_ROM = 2'd1,
    SRC_WIN = 2'd2
  } rd_src_e;

  localparam int unsigned ROM_BYTES = 64;

  function automatic logic [ROM_BYTES*8-1:0] default_rom();
    logic [ROM_BYTES*8-1:0] r;
    for (int i = 0; i < ROM_BYTES; i++) r[i*8 +: 8] = 8'(i * 29) ^ 8'h5A;
    return r;
  endfunction
endpackage

// File: rtl/ovl_flags.sv
module ovl_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_we_i,
  input  logic flag_rom_en_i,
  input  logic flag_ram_wr_i,
  output logic rom_en_o,
  output logic ram_wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_en_o <= 1'b1;
      ram_wr_o <= 1'b1;
    end else if (flag_we_i) begin
      rom_en_o <= flag_rom_en_i;
      ram_wr_o <= flag_ram_wr_i;
    end
  end
endmodule

// File: rtl/ovl_addr_gen.sv
module ovl_addr_gen
  import ovl_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter logic [7:0]  SP_RESET = 8'hEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  acc_kind_e     kind_i,
  input  logic          page_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_addr_o,
  output logic [DW-1:0] sp_o
);
  localparam int unsigned HI_W = AW - DW - 1;

  logic [DW-1:0] sp_q;
  logic [DW-1:0] sp_inc;

  assign sp_inc = sp_q + 1'b1;
  assign sp_o   = sp_q;

  always_comb begin
    unique case (kind_i)
      ACC_DP:   eff_addr_o = {{HI_W{1'b0}}, page_i, addr_i[DW-1:0]};
      ACC_PUSH: eff_addr_o = {{HI_W{1'b0}}, 1'b1, sp_q};
      ACC_POP:  eff_addr_o = {{HI_W{1'b0}}, 1'b1, sp_inc};
      default:  eff_addr_o = addr_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= SP_RESET[DW-1:0];
    else if (req_i) begin
      if (kind_i == ACC_PUSH)     sp_q <= sp_q - 1'b1;
      else if (kind_i == ACC_POP) sp_q <= sp_inc;
    end
  end
endmodule

// File: rtl/ovl_read_path.sv
module ovl_read_path
  import ovl_pkg::*;
#(
  parameter int unsigned           AW       = 16,
  parameter int unsigned           DW       = 8,
  parameter int unsigned           ROM_AW   = 6,
  parameter logic [(2**ROM_AW)*DW-1:0] ROM_INIT = default_rom(),
  parameter logic [15:0]           WIN_BASE = 16'h00F0,
  parameter int unsigned           WIN_AW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rom_en_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic [DW-1:0] win_rdata_i,
  output logic          win_hit_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  logic          rom_hit;
  rd_src_e       src_q;
  logic [DW-1:0] rom_q;
  logic          rvalid_q;

  assign rom_hit   = &addr_i[AW-1:ROM_AW];
  assign win_hit_o = addr_i[AW-1:WIN_AW] == WIN_BASE[AW-1:WIN_AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      src_q    <= SRC_RAM;
      rom_q    <= '0;
    end else begin
      rvalid_q <= rd_req_i;
      if (rd_req_i) begin
        // select registered to line up with the RAM's read latency
        if (win_hit_o)                src_q <= SRC_WIN;
        else if (rom_hit && rom_en_i) src_q <= SRC_ROM;
        else                          src_q <= SRC_RAM;
        rom_q <= ROM_INIT[addr_i[ROM_AW-1:0]*DW +: DW];
      end
    end
  end

  assign rvalid_o = rvalid_q;

  always_comb begin
    unique case (src_q)
      SRC_ROM: rdata_o = rom_q;
      SRC_WIN: rdata_o = win_rdata_i;
      default: rdata_o = ram_rdata_i;
    endcase
  end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import ovl_pkg::*;
#(
  parameter int unsigned               AW       = 16,
  parameter int unsigned               DW       = 8,
  parameter int unsigned               ROM_AW   = 6,
  parameter logic [(2**ROM_AW)*DW-1:0] ROM_INIT = default_rom(),
  parameter logic [15:0]               WIN_BASE = 16'h00F0,
  parameter int unsigned               WIN_AW   = 4,
  parameter logic [7:0]                SP_RESET = 8'hEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    kind_i,
  input  logic          we_i,
  input  logic          page_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          flag_we_i,
  input  logic          flag_rom_en_i,
  input  logic          flag_ram_wr_i,
  input  logic [DW-1:0] win_rdata_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          win_sel_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] sp_o
);
  acc_kind_e     kind;
  logic          rom_en;
  logic          ram_wr;
  logic          is_wr;
  logic          rd_req;
  logic          win_hit;
  logic [AW-1:0] eff_addr;

  assign kind   = acc_kind_e'(kind_i);
  assign is_wr  = (kind == ACC_PUSH) || ((kind != ACC_POP) && we_i);
  assign rd_req = req_i && !is_wr;

  ovl_flags u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flag_we_i     (flag_we_i),
    .flag_rom_en_i (flag_rom_en_i),
    .flag_ram_wr_i (flag_ram_wr_i),
    .rom_en_o      (rom_en),
    .ram_wr_o      (ram_wr)
  );

  ovl_addr_gen #(.AW(AW), .DW(DW), .SP_RESET(SP_RESET)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .kind_i     (kind),
    .page_i     (page_i),
    .addr_i     (addr_i),
    .eff_addr_o (eff_addr),
    .sp_o       (sp_o)
  );

  ovl_read_path #(
    .AW(AW), .DW(DW), .ROM_AW(ROM_AW), .ROM_INIT(ROM_INIT),
    .WIN_BASE(WIN_BASE), .WIN_AW(WIN_AW)
  ) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req),
    .addr_i      (eff_addr),
    .rom_en_i    (rom_en),
    .ram_rdata_i (ram_rdata_i),
    .win_rdata_i (win_rdata_i),
    .win_hit_o   (win_hit),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o)
  );

  // writes bypass the overlay and the window; only the writable flag gates them
  assign ram_we_o    = req_i && is_wr && ram_wr;
  assign ram_en_o    = rd_req || ram_we_o;
  assign ram_addr_o  = eff_addr;
  assign ram_wdata_o = wdata_i;
  assign win_sel_o   = req_i && win_hit;
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
  parameter int unsigned               AW       = 16,
  parameter int unsigned               DW       = 8,
  parameter int unsigned               ROM_AW   = 6,
  parameter logic [(2**ROM_AW)*DW-1:0] ROM_INIT = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [1:0]    kind_i,
  input logic          we_i,
  input logic [DW-1:0] win_rdata_i,
  input logic          ram_en_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o,
  input logic          win_sel_o,
  input logic          rvalid_o,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] sp_o,
  input logic          rom_en,
  input logic          ram_wr
);
  logic rd;
  logic rom_rd;
  assign rd     = req_i && (kind_i == 2'd3 || (kind_i != 2'd2 && !we_i));
  assign rom_rd = rd && rom_en && (&ram_addr_o[AW-1:ROM_AW]) && !win_sel_o;

  // R5
  wr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_wr && ram_en_o);

  // R8
  sp_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'd2) |=> sp_o == $past(sp_o) - 1'b1);

  // R8
  push_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'd2) |-> ram_addr_o == {{(AW-DW-1){1'b0}}, 1'b1, sp_o});

  // R9
  sp_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'd3) |=> sp_o == $past(sp_o) + 1'b1);

  // R10
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);

  // R2
  rom_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_rd |=> rdata_o == ROM_INIT[$past(ram_addr_o[ROM_AW-1:0])*DW +: DW]);

  // R6
  win_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && win_sel_o) |=> rdata_o == win_rdata_i);
endmodule

bind boot_overlay_decoder ovl_checker #(
  .AW(AW), .DW(DW), .ROM_AW(ROM_AW), .ROM_INIT(ROM_INIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .kind_i      (kind_i),
  .we_i        (we_i),
  .win_rdata_i (win_rdata_i),
  .ram_en_o    (ram_en_o),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .win_sel_o   (win_sel_o),
  .rvalid_o    (rvalid_o),
  .rdata_o     (rdata_o),
  .sp_o        (sp_o),
  .rom_en      (rom_en),
  .ram_wr      (ram_wr)
);

// File: tb/boot_overlay_decoder_test.sv
module boot_overlay_decoder_test;
  localparam logic [7:0] WIN_DATA = 8'hA5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic        we_i = 1'b0;
  logic        page_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        flag_we_i = 1'b0;
  logic        flag_rom_en_i = 1'b0;
  logic        flag_ram_wr_i = 1'b0;
  logic [7:0]  win_rdata_i = WIN_DATA;
  logic [7:0]  ram_rdata_i = '0;
  logic        ram_en_o, ram_we_o, win_sel_o, rvalid_o;
  logic [15:0] ram_addr_o;
  logic [7:0]  ram_wdata_o, rdata_o, sp_o;

  int checks = 0;
  int fails = 0;

  logic [7:0] ram_mem [logic [15:0]];
  logic [7:0] shadow  [logic [15:0]];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rom_en_m = 1'b1;
  logic       ram_wr_m = 1'b1;
  logic [7:0] sp_m = 8'hEF;

  always #10 clk_i = ~clk_i;

  boot_overlay_decoder uut (.*);

  // RAM model: synchronous single port, one-cycle read
  always @(posedge clk_i) begin
    if (ram_en_o) begin
      if (ram_we_o) ram_mem[ram_addr_o] = ram_wdata_o;
      else ram_rdata_i <= ram_mem.exists(ram_addr_o) ? ram_mem[ram_addr_o] : 8'h00;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_exp(input logic [5:0] i);
    return 8'((int'(i) * 29) % 256) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] model_read(input logic [15:0] a);
    if ((a & 16'hFFF0) == 16'h00F0) return WIN_DATA;
    if (a >= 16'hFFC0 && rom_en_m) return rom_exp(a[5:0]);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  // driver: one access per cycle, expected read data queued for the monitor
  task automatic access(input logic [1:0] k, input logic we, input logic pg,
                        input logic [15:0] a, input logic [7:0] d, input string tag);
    logic [15:0] ea;
    logic        wr;
    @(negedge clk_i);
    req_i = 1'b1; kind_i = k; we_i = we; page_i = pg; addr_i = a; wdata_i = d;
    wr = (k == 2'd2) || (k != 2'd3 && we);
    case (k)
      2'd1:    ea = {7'b0, pg, a[7:0]};
      2'd2:    ea = {8'h01, sp_m};
      2'd3:    ea = {8'h01, 8'(sp_m + 1)};
      default: ea = a;
    endcase
    #1;
    chk(ram_addr_o == ea, tag, ram_addr_o, ea);
    chk(win_sel_o == ((ea & 16'hFFF0) == 16'h00F0), tag, win_sel_o, 0);
    if (wr) begin
      chk(ram_we_o == ram_wr_m, tag, ram_we_o, ram_wr_m);
      if (ram_wr_m) shadow[ea] = d;
    end else begin
      exp_q.push_back(model_read(ea));
      tag_q.push_back(tag);
    end
    if (k == 2'd2) sp_m = sp_m - 1;
    if (k == 2'd3) sp_m = sp_m + 1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; flag_we_i = 1'b0;
  endtask

  task automatic set_flags(input logic rom_en, input logic ram_wr);
    @(negedge clk_i);
    req_i = 1'b0; flag_we_i = 1'b1; flag_rom_en_i = rom_en; flag_ram_wr_i = ram_wr;
    rom_en_m = rom_en; ram_wr_m = ram_wr;
    @(negedge clk_i);
    flag_we_i = 1'b0;
  endtask

  // monitor: pops one expectation per valid read
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (rst_ni && rvalid_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected rvalid", 1, 0);
        else begin
          logic [7:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rdata_o == e, t, rdata_o, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(sp_o == 8'hEF, "R1 sp reset", sp_o, 8'hEF);
    chk(rvalid_o == 1'b0, "R1 rvalid reset", rvalid_o, 0);
    chk(ram_we_o == 1'b0, "R1 we reset", ram_we_o, 0);
    rst_ni = 1'b1;

    // R2 overlay reads, R1 overlay on after reset
    access(2'd0, 1'b0, 1'b0, 16'hFFC0, 8'h00, "R2 rom FFC0");
    access(2'd0, 1'b0, 1'b0, 16'hFFC5, 8'h00, "R2 rom FFC5");
    access(2'd0, 1'b0, 1'b0, 16'hFFFF, 8'h00, "R2 rom FFFF");
    // R4 write under the ROM goes to RAM, reads still see ROM
    access(2'd0, 1'b1, 1'b0, 16'hFFC5, 8'h11, "R4 write under rom");
    access(2'd0, 1'b0, 1'b0, 16'hFFC5, 8'h00, "R2 rom still visible");
    // R11 R3 hide the ROM
    set_flags(1'b0, 1'b1);
    access(2'd0, 1'b0, 1'b0, 16'hFFC5, 8'h00, "R3 shadowed ram FFC5");
    access(2'd0, 1'b0, 1'b0, 16'hFFFF, 8'h00, "R3 ram FFFF");
    // R10 plain RAM
    access(2'd0, 1'b1, 1'b0, 16'h0200, 8'h33, "R10 write 0200");
    access(2'd0, 1'b0, 1'b0, 16'h0200, 8'h00, "R10 read 0200");
    // R7 direct page
    access(2'd1, 1'b1, 1'b1, 16'h0020, 8'h44, "R7 dp page1 write");
    access(2'd0, 1'b0, 1'b0, 16'h0120, 8'h00, "R7 abs read of page1");
    access(2'd1, 1'b0, 1'b0, 16'h0020, 8'h00, "R7 dp page0 read");
    access(2'd1, 1'b0, 1'b1, 16'h0020, 8'h00, "R7 dp page1 read");
    // R6 register window
    access(2'd0, 1'b1, 1'b0, 16'h00F4, 8'h55, "R6 window write");
    access(2'd0, 1'b0, 1'b0, 16'h00F4, 8'h00, "R6 window read");
    access(2'd0, 1'b0, 1'b0, 16'h00EF, 8'h00, "R6 below window");
    // R8 R9 stack
    access(2'd2, 1'b0, 1'b0, 16'h0000, 8'h66, "R8 push 1");
    access(2'd2, 1'b0, 1'b0, 16'h0000, 8'h77, "R8 push 2");
    idle();
    #1;
    chk(sp_o == 8'hED, "R8 sp after pushes", sp_o, 8'hED);
    access(2'd3, 1'b0, 1'b0, 16'h0000, 8'h00, "R9 pop 1");
    access(2'd3, 1'b0, 1'b0, 16'h0000, 8'h00, "R9 pop 2");
    idle();
    #1;
    chk(sp_o == 8'hEF, "R9 sp after pops", sp_o, 8'hEF);
    // R5 writes blocked
    set_flags(1'b0, 1'b0);
    access(2'd0, 1'b1, 1'b0, 16'h0200, 8'h99, "R5 blocked write");
    access(2'd2, 1'b0, 1'b0, 16'h0000, 8'h88, "R5 blocked push");
    set_flags(1'b1, 1'b1);
    access(2'd0, 1'b0, 1'b0, 16'h0200, 8'h00, "R5 ram unchanged");
    access(2'd0, 1'b1, 1'b0, 16'h00F8, 8'h5C, "R6 window write to ram");
    set_flags(1'b1, 1'b1);
    access(2'd0, 1'b0, 1'b0, 16'hFFC5, 8'h00, "R11 rom restored");
    idle();
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R10 reads outstanding", exp_q.size(), 0);
    chk((ram_mem.exists(16'h00F8) ? ram_mem[16'h00F8] : 8'h00) == 8'h5C,
        "R6 window write in ram", ram_mem.exists(16'h00F8) ? ram_mem[16'h00F8] : 8'h00, 8'h5C);
    finish_run();
  end
endmodule